// File: doc/BRIEF.md
# Cascaded Line Sensor Readout Register

This block models the digital readout path of a row of linear image sensor dies placed end to end. Each die carries a token register with one stage per photo-site. A token that is present in a stage selects that pixel. The selection stands in for the enable of the analog switch that connects the photo-site to the shared video line. The analog part itself, meaning the photo-sites, the video current and the charge integrator, is not modelled.

All state changes on the falling edge of the shift clock. A start input that is high at a falling edge loads a token into the first stage of the first die. After that the token moves one stage per falling edge, so one pixel is read per clock. Each die raises its end-of-scan output while its last pixel is selected. That output is the start input of the next die, so a line of `DIES × SITES` pixels is read with no gap between dies. The chain length and the pixels per die are parameters.

The block is also a checking aid. The model does not filter a start pulse that stays high across several falling edges. Every such edge loads a token, and the block reports this through a multi-token flag. A global pixel index reports the position of the leading token and has a valid flag.

Top module: `lsr_top`

## Requirements
- R1: A start input that is high at a falling clock edge selects pixel 0 of die 0 from that edge on. A start input that is low at a falling edge loads nothing.
- R2: At each falling edge every token moves from global position p to p+1, and a token at position DIES×SITES−1 leaves the chain. The pixel select vector has bit p set exactly while a token is at position p, where p = die×SITES + site.
- R3: The end-of-scan output of die k is high exactly while pixel SITES−1 of that die is selected. For k below DIES−1, pixel 0 of die k+1 is selected in the following clock period.
- R4: The final end-of-scan output is high exactly while the last pixel of the last die is selected.
- R5: A start input that is held high across n falling edges loads n tokens at n adjacent positions.
- R6: The valid flag is high while at least one token is present. The index then equals the highest selected global position, which is the token that entered first. While no token is present the index is 0.
- R7: The multi-token flag is high exactly while two or more tokens are present. It changes in the same clock period as the pixel selects.
- R8: A synchronous reset, sampled at a falling edge, clears every token, the flags, the index and all end-of-scan outputs. Nothing is selected afterwards until the start input is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; state changes on its falling edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Line start input of the first die |
| pix_sel_o | output | DIES×SITES | One-hot pixel selects, die k in bits k×SITES upward |
| die_eos_o | output | DIES | End-of-scan output of each die |
| eos_o | output | 1 | End-of-scan output of the last die |
| pix_idx_o | output | clog2(DIES×SITES) | Global position of the leading token |
| pix_vld_o | output | 1 | At least one token present |
| multi_tok_o | output | 1 | Two or more tokens present |

## Verification
The bench uses a small chain of three dies with four pixels each. A single one-cycle start pulse walks one token through all twelve positions. This shows stepping, the die-to-die handover and every end-of-scan output, each against its position. A start held high for two edges, and pairs of pulses at every spacing from adjacent to wider than the line, tell apart correct token injection and the multi-token flag. They also show that the index follows the leading token and not the trailing one. A reset in the middle of a scan, followed by idle clocks, shows that no token survives or reappears.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int DEF_DIES  = 13;
    localparam int DEF_SITES = 96;

    // global position of a pixel inside the chain
    function automatic int global_pos(input int die, input int site, input int sites);
        return die * sites + site;
    endfunction
endpackage

// File: rtl/lsr_die.sv
module lsr_die #(
    parameter int SITES = lsr_pkg::DEF_SITES
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    output logic [SITES-1:0] sel_o,
    output logic [SITES-1:0] sel_nxt_o,
    output logic             eos_o
);
    typedef struct packed {
        logic [SITES-1:0] tok;
    } die_state_t;

    die_state_t st_d, st_q;

    always_comb begin
        st_d.tok = {st_q.tok[SITES-2:0], start_i};
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(negedge clk_i) begin
        st_q <= st_d;
    end

    assign sel_o     = st_q.tok;
    assign sel_nxt_o = st_d.tok;
    assign eos_o     = st_q.tok[SITES-1];
endmodule

// File: rtl/lsr_pos_encode.sv
module lsr_pos_encode #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o,
    output logic          multi_o
);
    always_comb begin
        idx_o = '0;
        for (int p = 0; p < N; p++) begin
            if (vec_i[p]) begin
                idx_o = IW'(p);
            end
        end
        any_o   = |vec_i;
        multi_o = ($countones(vec_i) > 1);
    end
endmodule

// File: rtl/lsr_top.sv
module lsr_top #(
    parameter int DIES  = lsr_pkg::DEF_DIES,
    parameter int SITES = lsr_pkg::DEF_SITES
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            start_i,
    output logic [DIES*SITES-1:0]           pix_sel_o,
    output logic [DIES-1:0]                 die_eos_o,
    output logic                            eos_o,
    output logic [$clog2(DIES*SITES)-1:0]   pix_idx_o,
    output logic                            pix_vld_o,
    output logic                            multi_tok_o
);
    localparam int TOTAL = DIES * SITES;
    localparam int IW    = $clog2(TOTAL);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          vld;
        logic          multi;
    } sum_state_t;

    logic [DIES-1:0]  chain_in;
    logic [TOTAL-1:0] sel_nxt;
    logic [IW-1:0]    enc_idx;
    logic             enc_any;
    logic             enc_multi;
    sum_state_t       st_d, st_q;

    assign chain_in[0] = start_i;

    for (genvar k = 0; k < DIES; k++) begin : g_die
        if (k > 0) begin : g_link
            assign chain_in[k] = die_eos_o[k-1];
        end
        lsr_die #(.SITES(SITES)) i_die (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .start_i   (chain_in[k]),
            .sel_o     (pix_sel_o[lsr_pkg::global_pos(k, 0, SITES) +: SITES]),
            .sel_nxt_o (sel_nxt[lsr_pkg::global_pos(k, 0, SITES) +: SITES]),
            .eos_o     (die_eos_o[k])
        );
    end

    // encode next state so index and flag line up with the selects
    lsr_pos_encode #(.N(TOTAL), .IW(IW)) i_enc (
        .vec_i   (sel_nxt),
        .idx_o   (enc_idx),
        .any_o   (enc_any),
        .multi_o (enc_multi)
    );

    always_comb begin
        st_d.idx   = enc_idx;
        st_d.vld   = enc_any;
        st_d.multi = enc_multi;
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(negedge clk_i) begin
        st_q <= st_d;
    end

    assign eos_o       = die_eos_o[DIES-1];
    assign pix_idx_o   = st_q.idx;
    assign pix_vld_o   = st_q.vld;
    assign multi_tok_o = st_q.multi;
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
    parameter int DIES  = 13,
    parameter int SITES = 96
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          start_i,
    input logic [DIES*SITES-1:0]         pix_sel_o,
    input logic [DIES-1:0]               die_eos_o,
    input logic                          eos_o,
    input logic [$clog2(DIES*SITES)-1:0] pix_idx_o,
    input logic                          pix_vld_o,
    input logic                          multi_tok_o
);
    localparam int TOTAL = DIES * SITES;

    p_start_loads_r1: assert property (@(negedge clk_i) disable iff (rst_i)
        start_i |=> pix_sel_o[0]);

    p_count_kept_r2: assert property (@(negedge clk_i) disable iff (rst_i)
        1'b1 |=> ($countones(pix_sel_o) ==
                  $countones($past(pix_sel_o)) - int'($past(pix_sel_o[TOTAL-1])) + int'($past(start_i))));

    for (genvar k = 0; k < DIES - 1; k++) begin : g_hand
        p_handover_r3: assert property (@(negedge clk_i) disable iff (rst_i)
            die_eos_o[k] |=> pix_sel_o[(k+1)*SITES]);
    end

    p_final_eos_r4: assert property (@(negedge clk_i) disable iff (rst_i)
        eos_o |-> $past(pix_sel_o[TOTAL-2]));

    p_valid_r6: assert property (@(negedge clk_i) disable iff (rst_i)
        pix_vld_o == (pix_sel_o != '0));

    p_index_hit_r6: assert property (@(negedge clk_i) disable iff (rst_i)
        pix_vld_o |-> pix_sel_o[pix_idx_o]);

    p_multi_r7: assert property (@(negedge clk_i) disable iff (rst_i)
        multi_tok_o == ($countones(pix_sel_o) > 1));

    p_reset_clear_r8: assert property (@(negedge clk_i)
        rst_i |=> (pix_sel_o == '0) && !pix_vld_o && !multi_tok_o && !eos_o);
endmodule

bind lsr_top lsr_checker #(.DIES(DIES), .SITES(SITES)) i_lsr_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .pix_sel_o   (pix_sel_o),
    .die_eos_o   (die_eos_o),
    .eos_o       (eos_o),
    .pix_idx_o   (pix_idx_o),
    .pix_vld_o   (pix_vld_o),
    .multi_tok_o (multi_tok_o)
);

// File: tb/test_lsr_top.sv
module test_lsr_top;
    localparam int DIES  = 3;
    localparam int SITES = 4;
    localparam int TOTAL = DIES * SITES;
    localparam int IW    = $clog2(TOTAL);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [TOTAL-1:0] pix_sel;
    logic [DIES-1:0]  die_eos;
    logic             eos;
    logic [IW-1:0]    pix_idx;
    logic             pix_vld;
    logic             multi_tok;

    logic [TOTAL-1:0] mdl = '0;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lsr_top #(.DIES(DIES), .SITES(SITES)) i_lsr_top (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .pix_sel_o(pix_sel), .die_eos_o(die_eos), .eos_o(eos),
        .pix_idx_o(pix_idx), .pix_vld_o(pix_vld), .multi_tok_o(multi_tok)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // drive at rising edge, let the falling edge act, sample in low phase
    task automatic step(input logic r, input logic s);
        @(posedge clk);
        #1;
        rst   = r;
        start = s;
        @(negedge clk);
        #2;
        if (r) mdl = '0;
        else   mdl = {mdl[TOTAL-2:0], s};
    endtask

    task automatic compare();
        int hi;
        hi = 0;
        for (int p = 0; p < TOTAL; p++) if (mdl[p]) hi = p;
        chk("R2", "pix_sel", int'(pix_sel), int'(mdl));
        for (int k = 0; k < DIES; k++)
            chk("R3", "die_eos", int'(die_eos[k]), int'(mdl[k*SITES + SITES - 1]));
        chk("R4", "eos", int'(eos), int'(mdl[TOTAL-1]));
        chk("R6", "pix_vld", int'(pix_vld), int'(mdl != '0));
        chk("R6", "pix_idx", int'(pix_idx), hi);
        chk("R7", "multi_tok", int'(multi_tok), int'($countones(mdl) > 1));
    endtask

    task automatic run(input logic s);
        step(1'b0, s);
        compare();
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        // R8: reset state, start during reset ignored
        chk("R8", "sel after reset", int'(pix_sel), 0);
        chk("R8", "vld after reset", int'(pix_vld), 0);
        compare();

        // R1: low start loads nothing
        run(1'b0);
        chk("R1", "idle sel", int'(pix_sel), 0);

        // single token walk through the whole chain
        run(1'b1);
        chk("R1", "first pixel", int'(pix_sel), 1);
        for (int c = 0; c < TOTAL + 2; c++) run(1'b0);

        // R5: start held over two edges gives two adjacent tokens
        run(1'b1);
        run(1'b1);
        chk("R5", "two tokens", int'(pix_sel), 3);
        for (int c = 0; c < TOTAL + 2; c++) run(1'b0);

        // R5: three edges high
        run(1'b1); run(1'b1); run(1'b1);
        chk("R5", "three tokens", int'(pix_sel), 7);
        for (int c = 0; c < TOTAL + 2; c++) run(1'b0);

        // spacing sweep: two pulses g clocks apart
        for (int g = 2; g <= TOTAL + 1; g++) begin
            run(1'b1);
            for (int c = 1; c < g; c++) run(1'b0);
            run(1'b1);
            for (int c = 0; c < TOTAL + 1; c++) run(1'b0);
        end

        // R8: reset in the middle of a scan
        run(1'b1);
        for (int c = 0; c < 5; c++) run(1'b0);
        step(1'b1, 1'b0);
        chk("R8", "mid-scan reset sel", int'(pix_sel), 0);
        compare();
        for (int c = 0; c < TOTAL; c++) begin
            run(1'b0);
            chk("R8", "no token after reset", int'(pix_vld), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule